// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block sits between a synchronous host and an asynchronous static RAM. It turns a one-cycle write request into a complete, correctly timed write cycle on the memory pins. The RAM stores data only while three enables agree: chip-select low, the second chip enable high, and write-strobe low. The sequencer drives the address, both chip enables, the write strobe, a read-enable pin that it keeps inactive, and the write data. The data comes with a separate drive-enable, so that the tri-state buffer can sit at the pad.

The sequencer counts every phase in clock cycles. It derives each count from the clock period parameter and the speed grade. For each nanosecond limit, the count is the ceiling of the limit divided by the period. A zero-time limit still gets one cycle of margin. After reset, the host sees `req_ready` high. A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. The sequencer then latches the address and data, drops ready, and raises it again only once the full write-cycle time has been covered.

Top module: `sram_wr_seq`

## Requirements
- R1: While reset is held, and after it is released with no request, the outputs are: `req_ready`=1, `ram_ce1_n`=1, `ram_ce2`=0, `ram_we_n`=1, `ram_oe_n`=1 and `ram_dq_oe`=0.
- R2: A request is accepted only at an edge where `req_valid`=1 and `req_ready`=1. Its address and data are captured at that edge. `req_ready` is 0 from the next cycle until the memory cycle ends. Accepted writes reach the RAM in order, with the captured values.
- R3: `ram_we_n` is low only while `ram_ce1_n`=0 and `ram_ce2`=1. Each accepted request produces exactly one write-strobe pulse.
- R4: The write strobe stays low for at least the grade's pulse width: 50, 55 or 70 ns for grade codes 0, 1 and 2.
- R5: The data bus is driven only after the strobe has been low for at least the RAM's output-release time (25, 25 or 30 ns). The latched data is on the bus at least 25, 30 or 40 ns before the strobe rises.
- R6: The address and both chip enables are valid at least 45, 65 or 80 ns before the strobe rises. The address does not change while the chip is enabled.
- R7: After the strobe rises, the address, the chip enables and the driven data are held for at least one more clock cycle.
- R8: Successive strobe falls are at least 55, 70 or 100 ns apart. `req_ready` returns high only after a recovery phase in which the chip is disabled.
- R9: `ram_oe_n` is high in every cycle.
- R10: A request raised while `req_ready`=0 is ignored. Nothing is written for it.
- R11: The phase lengths follow the parameters. For setup, strobe-low, hold and recovery, in order, each output matches a per-cycle schedule built from these cycle counts:
  - Setup lasts one cycle.
  - Strobe-low lasts the largest of: the pulse-width count, the release count plus the data-setup count, and the address-setup count minus one.
  - Hold lasts one cycle.
  - Recovery is at least one cycle, enough to reach the write-cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host write request |
| req_addr | input | AW (18) | Write address |
| req_data | input | DW (8) | Write data |
| req_ready | output | 1 | High when a request can be accepted |
| ram_addr | output | AW (18) | Address to the RAM |
| ram_ce1_n | output | 1 | Active-low chip enable |
| ram_ce2 | output | 1 | Active-high chip enable |
| ram_we_n | output | 1 | Active-low write strobe |
| ram_oe_n | output | 1 | Active-low read enable, held inactive |
| ram_dq_o | output | DW (8) | Write data to the pad buffer |
| ram_dq_oe | output | 1 | Drive enable for the data pad buffer |

## Verification
The embedded assertions watch, on every cycle, the relationships that are local in time:
- the strobe stays inside the chip-enable window;
- the bus starts driving only after the strobe has been low for more than one cycle;
- bus and enables are held at the strobe's rising edge;
- the strobe pulse length is checked with a counter;
- the address stays stable while ready is low.

The nanosecond distances between edges, the spacing from one write cycle to the next, the order and content of the stored words, and the rejection of requests made while busy are all shown by the bench. It does this through its reference schedule and its edge-timestamping RAM model, across the single, boundary-address, back-to-back and busy-poke scenarios.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WE_LOW,
    ST_HOLD,
    ST_RECOVER
  } wr_state_e;

  typedef struct packed {
    logic ce1_n;
    logic ce2;
    logic we_n;
    logic drive;
    logic ready;
  } pin_vec_t;

  // clock cycles covering ns, at least one
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
    if (ns == 0) return 1;
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // grade code 0,1,2 -> limits in ns
  function automatic int unsigned lim_cycle(input int unsigned g);
    case (g)
      0: return 55;
      1: return 70;
      default: return 100;
    endcase
  endfunction

  function automatic int unsigned lim_pulse(input int unsigned g);
    case (g)
      0: return 50;
      1: return 55;
      default: return 70;
    endcase
  endfunction

  function automatic int unsigned lim_dsetup(input int unsigned g);
    case (g)
      0: return 25;
      1: return 30;
      default: return 40;
    endcase
  endfunction

  function automatic int unsigned lim_asetup(input int unsigned g);
    case (g)
      0: return 45;
      1: return 65;
      default: return 80;
    endcase
  endfunction

  function automatic int unsigned lim_release(input int unsigned g);
    return (g >= 2) ? 30 : 25;
  endfunction

endpackage

// File: rtl/sram_wr_latch.sv
module sram_wr_latch #(
  parameter int AW = 18,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_addr <= '0;
      out_data <= '0;
    end else if (capture) begin
      out_addr <= in_addr;
      out_data <= in_data;
    end
  end

endmodule

// File: rtl/sram_wr_fsm.sv
module sram_wr_fsm
  import sram_wr_pkg::*;
#(
  parameter int unsigned CLK_NS = 8,
  parameter int unsigned GRADE  = 0
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     start,
  output pin_vec_t pins_q
);

  localparam int unsigned N_SU   = ns2cyc(0, CLK_NS);
  localparam int unsigned N_HZ   = ns2cyc(lim_release(GRADE), CLK_NS);
  localparam int unsigned N_SD   = ns2cyc(lim_dsetup(GRADE), CLK_NS);
  localparam int unsigned N_PWE  = ns2cyc(lim_pulse(GRADE), CLK_NS);
  localparam int unsigned N_AW   = ns2cyc(lim_asetup(GRADE), CLK_NS);
  localparam int unsigned N_WC   = ns2cyc(lim_cycle(GRADE), CLK_NS);
  localparam int unsigned N_WE   = max2(max2(N_PWE, N_HZ + N_SD),
                                        (N_AW > N_SU) ? N_AW - N_SU : 1);
  localparam int unsigned N_HOLD = ns2cyc(0, CLK_NS);
  localparam int unsigned N_BUSY = N_SU + N_WE + N_HOLD + 1;
  localparam int unsigned N_REC  = (N_WC > N_BUSY) ? N_WC - N_BUSY + 1 : 1;
  localparam int unsigned N_MAX  = max2(max2(N_SU, N_WE), max2(N_HOLD, N_REC));
  localparam int unsigned CW     = $clog2(N_MAX + 1);
  localparam int unsigned DRV_AT = N_WE - 1 - N_HZ;

  wr_state_e      st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  pin_vec_t       pins_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = (cnt_q != '0) ? cnt_q - 1'b1 : '0;
    case (st_q)
      ST_IDLE:    if (start)         begin st_d = ST_SETUP;   cnt_d = CW'(N_SU - 1);   end
      ST_SETUP:   if (cnt_q == '0)   begin st_d = ST_WE_LOW;  cnt_d = CW'(N_WE - 1);   end
      ST_WE_LOW:  if (cnt_q == '0)   begin st_d = ST_HOLD;    cnt_d = CW'(N_HOLD - 1); end
      ST_HOLD:    if (cnt_q == '0)   begin st_d = ST_RECOVER; cnt_d = CW'(N_REC - 1);  end
      ST_RECOVER: if (cnt_q == '0)   begin st_d = ST_IDLE;    cnt_d = '0;              end
      default:                       begin st_d = ST_IDLE;    cnt_d = '0;              end
    endcase
  end

  // pin values of the next state, registered below
  always_comb begin
    pins_d = '{ce1_n: 1'b1, ce2: 1'b0, we_n: 1'b1, drive: 1'b0, ready: 1'b0};
    case (st_d)
      ST_IDLE:    pins_d.ready = 1'b1;
      ST_SETUP:   begin pins_d.ce1_n = 1'b0; pins_d.ce2 = 1'b1; end
      ST_WE_LOW:  begin
        pins_d.ce1_n = 1'b0;
        pins_d.ce2   = 1'b1;
        pins_d.we_n  = 1'b0;
        pins_d.drive = (cnt_d <= CW'(DRV_AT));
      end
      ST_HOLD:    begin pins_d.ce1_n = 1'b0; pins_d.ce2 = 1'b1; pins_d.drive = 1'b1; end
      default:    ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      pins_q <= '{ce1_n: 1'b1, ce2: 1'b0, we_n: 1'b1, drive: 1'b0, ready: 1'b1};
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      pins_q <= pins_d;
    end
  end

  // checker: length of the current strobe-low run
  logic [15:0] we_len_q;
  always_ff @(posedge clk) begin
    if (rst)               we_len_q <= '0;
    else if (!pins_q.we_n) we_len_q <= we_len_q + 16'd1;
    else                   we_len_q <= '0;
  end

  AST_WE_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    !pins_q.we_n |-> (!pins_q.ce1_n && pins_q.ce2)); // R3
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    !pins_q.ce1_n |-> !pins_q.ready); // R2
  AST_WE_PULSE_LEN: assert property (@(posedge clk) disable iff (rst)
    $rose(pins_q.we_n) |-> (we_len_q >= 16'(N_PWE))); // R4
  AST_DRIVE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $rose(pins_q.drive) |-> (!pins_q.we_n && $past(!pins_q.we_n))); // R5
  AST_HOLD_AT_WE_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(pins_q.we_n) |-> (pins_q.drive && !pins_q.ce1_n && pins_q.ce2)); // R7

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
  import sram_wr_pkg::*;
#(
  parameter int unsigned CLK_NS = 8,
  parameter int unsigned GRADE  = 0,
  parameter int          AW     = 18,
  parameter int          DW     = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          req_ready,
  output logic [AW-1:0] ram_addr,
  output logic          ram_ce1_n,
  output logic          ram_ce2,
  output logic          ram_we_n,
  output logic          ram_oe_n,
  output logic [DW-1:0] ram_dq_o,
  output logic          ram_dq_oe
);

  pin_vec_t pins;
  logic     accept;

  assign accept = req_valid && pins.ready;

  sram_wr_latch #(.AW(AW), .DW(DW)) latch_i (
    .clk      (clk),
    .rst      (rst),
    .capture  (accept),
    .in_addr  (req_addr),
    .in_data  (req_data),
    .out_addr (ram_addr),
    .out_data (ram_dq_o)
  );

  sram_wr_fsm #(.CLK_NS(CLK_NS), .GRADE(GRADE)) fsm_i (
    .clk    (clk),
    .rst    (rst),
    .start  (accept),
    .pins_q (pins)
  );

  // read enable stays inactive: writes only
  always_ff @(posedge clk) begin
    ram_oe_n <= 1'b1;
  end

  assign req_ready = pins.ready;
  assign ram_ce1_n = pins.ce1_n;
  assign ram_ce2   = pins.ce2;
  assign ram_we_n  = pins.we_n;
  assign ram_dq_oe = pins.drive;

  AST_ADDR_STABLE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && $past(!req_ready)) |-> ($stable(ram_addr) && $stable(ram_dq_o))); // R6
  AST_NO_DRIVE_IDLE: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!ram_dq_oe && ram_we_n)); // R10

endmodule

// File: tb/sram_wr_seq_tb_top.sv
module sram_wr_seq_tb_top;

  localparam int CLK_NS = 8;
  localparam int GRADE  = 0;
  localparam int AW     = 18;
  localparam int DW     = 8;

  function automatic int bcyc(input int ns);
    int n = 1;
    while (n * CLK_NS < ns) n++;
    return n;
  endfunction
  function automatic int g_pick(input int a, input int b, input int c);
    return (GRADE == 0) ? a : (GRADE == 1) ? b : c;
  endfunction

  localparam int T_WC = g_pick(55, 70, 100);
  localparam int T_PW = g_pick(50, 55, 70);
  localparam int T_SD = g_pick(25, 30, 40);
  localparam int T_AW = g_pick(45, 65, 80);
  localparam int T_HZ = g_pick(25, 25, 30);

  localparam int E_SU   = 1;
  localparam int E_HZ   = bcyc(T_HZ);
  localparam int E_WE_A = (bcyc(T_PW) > E_HZ + bcyc(T_SD)) ? bcyc(T_PW) : E_HZ + bcyc(T_SD);
  localparam int E_WE   = (E_WE_A > bcyc(T_AW) - 1) ? E_WE_A : bcyc(T_AW) - 1;
  localparam int E_HOLD = 1;
  localparam int E_REC  = (bcyc(T_WC) - (E_SU + E_WE + E_HOLD + 1) > 1) ?
                          bcyc(T_WC) - (E_SU + E_WE + E_HOLD + 1) : 1;
  localparam int E_TOT  = E_SU + E_WE + E_HOLD + E_REC;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          req_ready, ram_ce1_n, ram_ce2, ram_we_n, ram_oe_n, ram_dq_oe;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_dq_o;

  always #4 clk = ~clk;

  sram_wr_seq #(.CLK_NS(CLK_NS), .GRADE(GRADE), .AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data),
    .req_ready(req_ready), .ram_addr(ram_addr), .ram_ce1_n(ram_ce1_n), .ram_ce2(ram_ce2),
    .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n), .ram_dq_o(ram_dq_o), .ram_dq_oe(ram_dq_oe)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit mon_on = 0;

  task automatic chk(input string tag, input bit ok, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference schedule
  typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; } wr_t;
  wr_t             pend[$];
  logic [DW-1:0]   exp_mem[int];
  logic [DW-1:0]   ram_mem[int];
  int              pos = 0;
  int              cyc_n = 0;
  logic [AW-1:0]   m_addr = '0;
  logic [DW-1:0]   m_data = '0;

  always @(posedge clk) begin
    cyc_n++;
    if (rst) pos = 0;
    else if (pos == 0) begin
      if (req_valid) begin
        pos = 1;
        m_addr = req_addr;
        m_data = req_data;
        pend.push_back('{a: req_addr, d: req_data});
        exp_mem[int'(req_addr)] = req_data;
      end
    end else if (pos == E_TOT) pos = 0;
    else pos++;
  end

  // {ready, ce1_n, ce2, we_n, drive}
  function automatic logic [4:0] exp_vec(input int p);
    if (p == 0) return 5'b11010;
    if (p <= E_SU) return 5'b00110;
    if (p <= E_SU + E_WE) return {4'b0010, (p - E_SU - 1 >= E_HZ)};
    if (p <= E_SU + E_WE + E_HOLD) return 5'b00111;
    return 5'b01010;
  endfunction

  // edge-timestamping RAM model
  int   t_wf = 0, t_wr = 0, t_ce = 0, t_addr = 0, t_d = 0;
  bit   have_wf = 0;
  logic p_we = 1, p_ce = 0, p_drv = 0;
  logic [AW-1:0] p_addr = '0;
  logic [DW-1:0] p_dq = '0;

  always @(negedge clk) begin
    if (mon_on) begin
      int   t;
      logic ce_act;
      logic [4:0] act;
      t = cyc_n * CLK_NS;
      ce_act = !ram_ce1_n && ram_ce2;
      act = {req_ready, ram_ce1_n, ram_ce2, ram_we_n, ram_dq_oe};
      chk("R11 per-cycle schedule", act == exp_vec(pos), 64'(act), 64'(exp_vec(pos)));
      chk("R9 oe_n high", ram_oe_n == 1'b1, 64'(ram_oe_n), 64'd1);
      if (ce_act) chk("R6 address", ram_addr == m_addr, 64'(ram_addr), 64'(m_addr));
      if (ram_dq_oe) chk("R5 data", ram_dq_o == m_data, 64'(ram_dq_o), 64'(m_data));
      if (!ram_we_n) chk("R3 strobe in window", ce_act, 64'(ce_act), 64'd1);
      if (ce_act && !p_ce) t_ce = t;
      if (!ce_act && p_ce) chk("R7 ce hold", t - t_wr >= CLK_NS, 64'(t - t_wr), 64'(CLK_NS));
      if (ram_addr != p_addr) begin
        t_addr = t;
        if (ce_act && p_ce) chk("R6 addr moved while enabled", 1'b0, 64'(ram_addr), 64'(p_addr));
      end
      if (ram_dq_oe && !p_drv) begin
        chk("R5 release time", (t - t_wf >= T_HZ) && !ram_we_n, 64'(t - t_wf), 64'(T_HZ));
        t_d = t;
      end
      if (ram_dq_oe && p_drv && ram_dq_o != p_dq)
        chk("R5 data moved while driven", 1'b0, 64'(ram_dq_o), 64'(p_dq));
      if (!ram_we_n && p_we) begin
        if (have_wf) chk("R8 cycle time", t - t_wf >= T_WC, 64'(t - t_wf), 64'(T_WC));
        t_wf = t;
        have_wf = 1;
      end
      if (ram_we_n && !p_we) begin
        chk("R4 pulse width", t - t_wf >= T_PW, 64'(t - t_wf), 64'(T_PW));
        chk("R5 data setup", ram_dq_oe && (t - t_d >= T_SD), 64'(t - t_d), 64'(T_SD));
        chk("R6 ce setup", t - t_ce >= T_AW, 64'(t - t_ce), 64'(T_AW));
        chk("R6 addr setup", t - t_addr >= T_AW, 64'(t - t_addr), 64'(T_AW));
        t_wr = t;
        if (ce_act) begin
          ram_mem[int'(ram_addr)] = ram_dq_o;
          if (pend.size() == 0) chk("R3 extra strobe", 1'b0, 64'd1, 64'd0);
          else begin
            wr_t w;
            w = pend.pop_front();
            chk("R2 write order/addr", ram_addr == w.a, 64'(ram_addr), 64'(w.a));
            chk("R2 write order/data", ram_dq_o == w.d, 64'(ram_dq_o), 64'(w.d));
          end
        end
      end
      if (!ram_dq_oe && p_drv)
        chk("R7 data hold", (t - t_wr >= CLK_NS) && ram_we_n, 64'(t - t_wr), 64'(CLK_NS));
      p_we = ram_we_n; p_ce = ce_act; p_drv = ram_dq_oe; p_addr = ram_addr; p_dq = ram_dq_o;
    end
  end

  task automatic wait_ready();
    @(negedge clk);
    while (pos != 0) @(negedge clk);
  endtask

  task automatic send(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wait_ready();
    req_valid = 1'b1; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 reset ready", req_ready == 1'b1, 64'(req_ready), 64'd1);
    chk("R1 reset pins", {ram_ce1_n, ram_ce2, ram_we_n, ram_oe_n, ram_dq_oe} == 5'b10110,
        64'({ram_ce1_n, ram_ce2, ram_we_n, ram_oe_n, ram_dq_oe}), 64'h16);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", {req_ready, ram_we_n, ram_dq_oe} == 3'b110,
        64'({req_ready, ram_we_n, ram_dq_oe}), 64'h6);
    mon_on = 1;
    repeat (3) @(negedge clk);

    send(18'h00000, 8'hA5);
    send(18'h3FFFF, 8'h5A);
    send(18'h15555, 8'hFF);
    send(18'h2AAAA, 8'h00);

    // R10: poke while busy, must be ignored
    send(18'h00400, 8'h3C);
    req_valid = 1'b1; req_addr = 18'h00123; req_data = 8'hEE;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 18'h00123; req_data = 8'hEE;
    @(negedge clk);
    req_valid = 1'b0;

    // R8: valid held high, back-to-back writes
    wait_ready();
    req_valid = 1'b1; req_addr = 18'h01000; req_data = 8'h11;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      while (pos != 1) @(negedge clk);
      if (k < 3) begin
        req_addr = 18'h01000 + 18'(k);
        req_data = 8'h11 + 8'(k);
      end else req_valid = 1'b0;
    end

    send(18'h00000, 8'h77);  // overwrite
    wait_ready();
    repeat (5) @(negedge clk);

    chk("R10 busy request not written", !ram_mem.exists(32'h123), 64'(ram_mem.exists(32'h123)), 64'd0);
    chk("R3 one strobe per request", pend.size() == 0, 64'(pend.size()), 64'd0);
    foreach (exp_mem[k]) begin
      chk("R2 stored word present", ram_mem.exists(k), 64'(ram_mem.exists(k)), 64'd1);
      if (ram_mem.exists(k))
        chk("R2 stored word value", ram_mem[k] == exp_mem[k], 64'(ram_mem[k]), 64'(exp_mem[k]));
    end
    done = 1;
    summary();
    $finish;
  end

endmodule